// File: doc/BRIEF.md
# Extended-Accumulator Subtract Unit

This unit is the subtract slice of a 16-bit fixed-point signal-controller datapath. It holds two 36-bit accumulators, each made of a 4-bit extension field, a 16-bit high word and a 16-bit low word. On each execute strobe it subtracts a source operand from the chosen destination accumulator and writes the 36-bit difference back to that accumulator.

The source operand can be one of three things. It can be the other accumulator. It can be a 16-bit word, either a signed immediate or a value taken from a register or memory. It can also be a 5-bit unsigned immediate. Every 16-bit source is placed in the high word before the subtraction. The sign is copied into the extension field and the low word is filled with zeros.

A condition-code register is updated on the same clock edge as the destination accumulator. It holds these flags:
- negative
- zero
- overflow
- borrow
- extension-in-use
- unnormalized
- sticky limit

The limit flag stays set until a separate clear input is asserted. Instruction decode, addressing and moves take place outside this unit.

Top module: `xacc_sub`

## Requirements
- R1: A synchronous active-high reset sets both accumulators and all seven condition bits to zero.
- R2: When the execute strobe is low, both accumulators and condition bits 5..0 keep their values whatever the other inputs are.
- R3: With source kind 0 (accumulator), the destination (select 0 = accumulator A, 1 = accumulator B) becomes destination minus the other accumulator, modulo 2^36. The other accumulator does not change.
- R4: With source kind 1 (word), the 16-bit word is sign-extended into bits 35..32, placed in bits 31..16, and given zeros in bits 15..0 before it is subtracted.
- R5: With source kind 2 (small immediate), only word bits 4..0 are used. They are zero-extended to a 16-bit value and aligned as in R4. Word bits 15..5 have no effect.
- R6: With source kind 3 (signed immediate), the word is a signed 16-bit integer aligned exactly as in R4.
- R7: Condition bit 3 (N) equals result bit 35. Condition bit 2 (Z) is set exactly when all 36 result bits are zero.
- R8: Condition bit 1 (V) is set when the 36-bit two's-complement subtraction overflows. Condition bit 0 (C) is set when a borrow leaves bit 35, which means the destination is below the source as unsigned 36-bit values.
- R9: Condition bit 5 (E) is set when result bits 35..31 are not all equal.
- R10: Condition bit 4 (U) equals NOT(result bit 31 XOR result bit 30).
- R11: Condition bit 6 (L) is set by any executed subtraction that overflows. Once set, it stays set until the clear input is high at a clock edge. If an overflowing subtraction executes on that same edge, setting takes priority over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe; the subtraction commits on this edge |
| dst_sel_i | input | 1 | Destination: 0 = accumulator A, 1 = accumulator B |
| src_kind_i | input | 2 | 0 = other accumulator, 1 = word, 2 = small unsigned immediate, 3 = signed immediate |
| src_word_i | input | 16 | 16-bit source value (register, memory or immediate) |
| clr_lim_i | input | 1 | Clears the sticky limit flag |
| acc_a_o | output | 36 | Accumulator A |
| acc_b_o | output | 36 | Accumulator B |
| ccr_o | output | 7 | Condition bits {L,E,U,N,Z,V,C}, bit 6 down to bit 0 |

## Verification
The small immediate is swept over all 32 values, and each one is paired with different garbage in word bits 15..5. This separates correct zero-extension from any leak of the upper bits. Word and signed-immediate sources are run over 256 spread patterns per kind, alternating the destination, so that sign extension and low-word zero fill are both exposed. Accumulator-to-accumulator runs cover equal operands (zero, no borrow) and unequal operands (borrow, negative). A chain of repeated subtractions of the most negative word drives accumulator A through extension use and into a wrap at 2^35. This case exercises overflow, the limit flag staying set, clearing it, and the set-over-clear priority.

// File: rtl/xacc_sub_pkg.sv
package xacc_sub_pkg;

  typedef enum logic [1:0] {
    SRC_ACC  = 2'd0,
    SRC_WORD = 2'd1,
    SRC_UIMM = 2'd2,
    SRC_SIMM = 2'd3
  } src_kind_e;

  // Condition bits, MSB first: lim(6) ext(5) unnorm(4) neg(3) zero(2) ovf(1) carry(0)
  typedef struct packed {
    logic lim;
    logic ext;
    logic unnorm;
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } ccr_t;

  localparam int CCR_W = $bits(ccr_t);

endpackage

// File: rtl/xacc_sub_align.sv
module xacc_sub_align
  import xacc_sub_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  parameter int UIMM_W = 5
) (
  input  src_kind_e                     kind_i,
  input  logic [WORD_W-1:0]             word_i,
  input  logic [EXT_W+2*WORD_W-1:0]     other_acc_i,
  output logic [EXT_W+2*WORD_W-1:0]     operand_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int UPAD  = ACC_W - WORD_W - UIMM_W;

  logic [ACC_W-1:0] word_aligned;
  logic [ACC_W-1:0] uimm_aligned;

  always_comb begin
    word_aligned = {{EXT_W{word_i[WORD_W-1]}}, word_i, {WORD_W{1'b0}}};
    uimm_aligned = {{UPAD{1'b0}}, word_i[UIMM_W-1:0], {WORD_W{1'b0}}};
  end

  always_comb begin
    unique case (kind_i)
      SRC_ACC:  operand_o = other_acc_i;
      SRC_UIMM: operand_o = uimm_aligned;
      default:  operand_o = word_aligned;
    endcase
  end

endmodule

// File: rtl/xacc_sub_core.sv
module xacc_sub_core
  import xacc_sub_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic [EXT_W+2*WORD_W-1:0] dst_i,
  input  logic [EXT_W+2*WORD_W-1:0] src_i,
  output logic [EXT_W+2*WORD_W-1:0] diff_o,
  output logic                      ext_o,
  output logic                      unnorm_o,
  output logic                      neg_o,
  output logic                      zero_o,
  output logic                      ovf_o,
  output logic                      carry_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int MSB   = ACC_W - 1;
  localparam int NRM   = 2*WORD_W - 1;
  localparam int HI_W  = EXT_W + 1;

  logic [ACC_W:0]   wide;
  logic [HI_W-1:0]  hi_bits;

  always_comb begin
    wide     = {1'b0, dst_i} - {1'b0, src_i};
    diff_o   = wide[MSB:0];
    carry_o  = wide[ACC_W];
    ovf_o    = (dst_i[MSB] ^ src_i[MSB]) & (diff_o[MSB] ^ dst_i[MSB]);
    neg_o    = diff_o[MSB];
    zero_o   = ~|diff_o;
    hi_bits  = diff_o[MSB:NRM];
    ext_o    = ~((&hi_bits) | (~|hi_bits));
    unnorm_o = ~(diff_o[NRM] ^ diff_o[NRM-1]);
  end

endmodule

// File: rtl/xacc_sub.sv
module xacc_sub
  import xacc_sub_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  parameter int UIMM_W = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      exec_i,
  input  logic                      dst_sel_i,
  input  logic [1:0]                src_kind_i,
  input  logic [WORD_W-1:0]         src_word_i,
  input  logic                      clr_lim_i,
  output logic [EXT_W+2*WORD_W-1:0] acc_a_o,
  output logic [EXT_W+2*WORD_W-1:0] acc_b_o,
  output logic [CCR_W-1:0]          ccr_o
);
  localparam int ACC_W   = EXT_W + 2*WORD_W;
  localparam int NUM_ACC = 2;

  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [ACC_W-1:0] dst_val, other_val, src_op, diff;
  logic             f_ext, f_unnorm, f_neg, f_zero, f_ovf, f_carry;
  ccr_t             ccr_q;

  always_comb begin
    dst_val   = acc_q[dst_sel_i];
    other_val = acc_q[~dst_sel_i];
  end

  xacc_sub_align #(.EXT_W(EXT_W), .WORD_W(WORD_W), .UIMM_W(UIMM_W)) u_align (
    .kind_i      (src_kind_e'(src_kind_i)),
    .word_i      (src_word_i),
    .other_acc_i (other_val),
    .operand_o   (src_op)
  );

  xacc_sub_core #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_core (
    .dst_i    (dst_val),
    .src_i    (src_op),
    .diff_o   (diff),
    .ext_o    (f_ext),
    .unnorm_o (f_unnorm),
    .neg_o    (f_neg),
    .zero_o   (f_zero),
    .ovf_o    (f_ovf),
    .carry_o  (f_carry)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[g] <= '0;
      else if (exec_i && (dst_sel_i == 1'(g)))
        acc_q[g] <= diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q <= '0;
    end else begin
      if (exec_i) begin
        ccr_q.ext    <= f_ext;
        ccr_q.unnorm <= f_unnorm;
        ccr_q.neg    <= f_neg;
        ccr_q.zero   <= f_zero;
        ccr_q.ovf    <= f_ovf;
        ccr_q.carry  <= f_carry;
      end
      ccr_q.lim <= (ccr_q.lim & ~clr_lim_i) | (exec_i & f_ovf);
    end
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign ccr_o   = ccr_q;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_a_o == '0) && (acc_b_o == '0) && (ccr_o == '0));

  // R2
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(ccr_o[5:0]));

  // R3
  a_r3_b_untouched: assert property (@(posedge clk) disable iff (rst)
    (exec_i && !dst_sel_i) |=> $stable(acc_b_o));
  a_r3_a_untouched: assert property (@(posedge clk) disable iff (rst)
    (exec_i && dst_sel_i) |=> $stable(acc_a_o));

  // R7
  a_r7_neg_zero_track: assert property (@(posedge clk) disable iff (rst)
    (exec_i && !dst_sel_i) |=> (ccr_o[3] == acc_a_o[ACC_W-1]) && (ccr_o[2] == (acc_a_o == '0)));

  // R8
  a_r8_ovf_needs_sign_mismatch: assert property (@(posedge clk) disable iff (rst)
    (exec_i && f_ovf) |-> (dst_val[ACC_W-1] != src_op[ACC_W-1]));

  // R11
  a_r11_lim_set: assert property (@(posedge clk) disable iff (rst)
    (exec_i && f_ovf) |=> ccr_o[6]);
  a_r11_lim_sticky: assert property (@(posedge clk) disable iff (rst)
    (ccr_o[6] && !clr_lim_i) |=> ccr_o[6]);
  a_r11_lim_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_lim_i && !exec_i) |=> !ccr_o[6]);

endmodule

// File: tb/xacc_sub_tb.sv
`timescale 1ns/1ps
module xacc_sub_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_i = 1'b0;
  logic        dst_sel_i = 1'b0;
  logic [1:0]  src_kind_i = 2'd0;
  logic [15:0] src_word_i = 16'h0;
  logic        clr_lim_i = 1'b0;
  logic [35:0] acc_a_o, acc_b_o;
  logic [6:0]  ccr_o;

  int checks = 0;
  int errors = 0;

  logic [35:0] m_a, m_b;
  logic [6:0]  m_ccr;

  always #2.5 clk = ~clk;

  xacc_sub u_dut (
    .clk(clk), .rst(rst), .exec_i(exec_i), .dst_sel_i(dst_sel_i),
    .src_kind_i(src_kind_i), .src_word_i(src_word_i), .clr_lim_i(clr_lim_i),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ccr_o(ccr_o)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " acc A"}, acc_a_o, m_a);
    chk({tag, " acc B"}, acc_b_o, m_b);
    chk({tag, " flags R7 R8 R9 R10 R11"}, {29'h0, ccr_o}, {29'h0, m_ccr});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; exec_i = 1'b0; clr_lim_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_a = '0; m_b = '0; m_ccr = '0;
  endtask

  task automatic step(input logic d, input logic [1:0] k, input logic [15:0] w,
                      input logic ex, input logic clr, input string tag);
    logic [35:0] dv, ov, src, res;
    logic [36:0] r;
    logic v;
    @(negedge clk);
    dst_sel_i = d; src_kind_i = k; src_word_i = w; exec_i = ex; clr_lim_i = clr;
    dv = d ? m_b : m_a;
    ov = d ? m_a : m_b;
    case (k)
      2'd0: src = ov;
      2'd2: src = {4'h0, 11'h0, w[4:0], 16'h0};
      default: src = {{4{w[15]}}, w, 16'h0};
    endcase
    r   = {1'b0, dv} - {1'b0, src};
    res = r[35:0];
    v   = (dv[35] != src[35]) && (res[35] != dv[35]);
    if (ex) begin
      if (d) m_b = res; else m_a = res;
      m_ccr[5] = !((res[35:31] == 5'h00) || (res[35:31] == 5'h1f));
      m_ccr[4] = ~(res[31] ^ res[30]);
      m_ccr[3] = res[35];
      m_ccr[2] = (res == 36'h0);
      m_ccr[1] = v;
      m_ccr[0] = r[36];
    end
    m_ccr[6] = (m_ccr[6] & ~clr) | (ex & v);
    @(negedge clk);
    exec_i = 1'b0; clr_lim_i = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_a = '0; m_b = '0; m_ccr = '0;
    do_reset();
    compare_all("R1 reset state");

    // Equal accumulators: zero result, no borrow
    step(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, "R3 R7 equal acc");

    // Small immediate sweep with garbage in upper word bits
    for (int i = 0; i < 32; i++)
      step(i[0], 2'd2, {11'(i * 37 + 5), 5'(i)}, 1'b1, 1'b0, "R5 uimm sweep");

    // Word and signed immediate sweeps
    for (int i = 0; i < 256; i++)
      step(i[0], 2'd1, 16'(i * 257) ^ 16'h1234, 1'b1, 1'b0, "R4 word sweep");
    for (int i = 0; i < 256; i++)
      step(i[1], 2'd3, 16'(i * 4099) ^ 16'h8a51, 1'b1, 1'b0, "R6 simm sweep");

    // Accumulator-to-accumulator
    for (int i = 0; i < 64; i++)
      step(i[0], 2'd0, 16'(i), 1'b1, 1'b0, "R3 acc sweep");

    // Idle cycles with changing inputs
    for (int i = 0; i < 8; i++)
      step(i[0], 2'(i), 16'hffff ^ 16'(i), 1'b0, 1'b0, "R2 hold");

    // Overflow chain: subtract most negative word until A wraps
    do_reset();
    compare_all("R1 reset again");
    for (int i = 0; i < 20; i++)
      step(1'b0, 2'd1, 16'h8000, 1'b1, 1'b0, "R8 R9 R11 overflow chain");
    step(1'b1, 2'd2, 16'h0003, 1'b1, 1'b0, "R11 sticky after normal op");
    step(1'b0, 2'd1, 16'h0000, 1'b0, 1'b1, "R11 clear");
    step(1'b1, 2'd1, 16'h0001, 1'b1, 1'b0, "R11 stays clear");

    // Set beats clear on the same edge
    do_reset();
    for (int i = 0; i < 15; i++)
      step(1'b0, 2'd1, 16'h8000, 1'b1, 1'b0, "R9 R10 build-up");
    step(1'b0, 2'd1, 16'h8000, 1'b1, 1'b1, "R11 set over clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule